// File: doc/BRIEF.md
# Block-Transfer Sequencer Core

This is a very small programmable sequencer that carries out block copies between a peripheral port and system memory. It runs a short program held in an external ROM. It has eight general-purpose registers, a one-bit equality flag and a program counter. The core shares the system bus with a host processor. Each instruction that touches memory or I/O space raises a bus request and waits until the host grants the bus. Instructions that stay inside the core never wait.

Instruction words are 16 bits wide. The 4-bit opcode alone decides whether a second word follows, and that second word is a 16-bit immediate which the core sign-extends. A start pulse launches the program at address 0. Reaching the end instruction pulses `done` for one cycle and, if interrupts are enabled, raises `irq`. An undefined opcode stops the core and sets `err`.

Top module: `dma_seq_core`

## Requirements
- R1: After reset the core is halted, and `done`, `err`, `irq`, `bus_req`, `bus_rd` and `bus_wr` are all 0, with `rom_addr` equal to 0.
- R2: A `start` pulse sets the program counter to 0, makes the core run, and clears `err` and `irq`. The register contents are kept.
- R3: `bus_rd` and `bus_wr` are asserted only in a cycle where both `bus_req` and `bus_gnt` are 1. While `bus_req` is 1 and `bus_gnt` is 0, the core stalls and `rom_addr` holds its value.
- R4: The word layout is opcode [15:12], first field [11:4] (port number, or register number in [6:4]) and second register [2:0]. The single-word bus opcodes are 8h (write register b to I/O port), 9h (read I/O port into register b), Ah (write register b to the memory address held in register a) and Bh (read the memory address held in register a into register b). `bus_io` is 1 for I/O accesses and 0 for memory accesses.
- R5: The two-word opcodes take the next ROM word as an immediate and sign-extend it to the data width. 4h loads register a with it, 5h adds it to register a, and Ch writes it to I/O port [11:4].
- R6: Opcode 6h (two words) sets the flag when register a equals the immediate and clears it otherwise. No other opcode changes the flag. Opcode 1h jumps to [11:0] only when the flag is set, and opcode 2h always jumps there.
- R7: Opcode 3h halts the core and makes `done` 1 for exactly one cycle. Opcode 0h does nothing.
- R8: When the core halts on opcode 3h with `irq_en` at 1, `irq` becomes 1 and stays 1 until the next `start`. With `irq_en` at 0, `irq` stays 0.
- R9: Opcodes 7h, Dh, Eh and Fh halt the core and set `err`. `done` does not pulse and `irq` is not raised.
- R10: Once the core has halted, it makes no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch the program from address 0 |
| irq_en | input | 1 | Interrupt mode enable |
| done | output | 1 | One-cycle pulse when the program ends |
| err | output | 1 | Set when an undefined opcode is reached |
| irq | output | 1 | Completion interrupt, held until the next start |
| rom_addr | output | PCW | Program ROM address (the program counter) |
| rom_data | input | 16 | ROM word at `rom_addr`, available in the same cycle |
| bus_req | output | 1 | Core requests the shared bus |
| bus_gnt | input | 1 | Host leaves the bus free in this cycle |
| bus_io | output | 1 | 1 selects I/O space, 0 selects memory |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | DW | Memory address or port number |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, sampled in the read cycle |

## Verification
The main pattern is a copy loop that reads a port eight times and stores each word to consecutive memory addresses while the bus grant is withheld at random. Correct memory contents and the right order of reads show that stalls neither drop nor repeat an access. A directed run holds the grant low for many cycles to show a true stall. Other short programs do the following: one uses an all-ones immediate to tell sign extension from zero extension, one takes a flag-driven branch to show that a skipped write never reaches the bus, and one ends on an undefined opcode to tell the error halt from the normal end.

// File: rtl/dma_seq_core.sv
module dma_seq_core #(
  parameter int DW   = 32,
  parameter int PCW  = 12,
  parameter int NREG = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           irq_en,
  output logic           done,
  output logic           err,
  output logic           irq,
  output logic [PCW-1:0] rom_addr,
  input  logic [15:0]    rom_data,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           bus_io,
  output logic           bus_rd,
  output logic           bus_wr,
  output logic [DW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata
);
  localparam int RIW = $clog2(NREG);

  typedef enum logic [1:0] {S_HALT, S_RUN, S_IMM} st_t;

  st_t            state;
  logic [PCW-1:0] pc;
  logic [15:0]    ir;
  logic [DW-1:0]  rf [NREG];
  logic           eq;

  logic [15:0]    cur;
  logic [3:0]     op;
  logic [RIW-1:0] ra, rb;
  logic [DW-1:0]  imm, port_ext;
  logic           mem_op, wr_op, rd_op;

  assign cur      = (state == S_IMM) ? ir : rom_data;
  assign op       = cur[15:12];
  assign ra       = cur[4 +: RIW];
  assign rb       = cur[RIW-1:0];
  assign imm      = {{(DW-16){rom_data[15]}}, rom_data};
  assign port_ext = {{(DW-8){1'b0}}, cur[11:4]};
  assign rom_addr = pc;

  assign bus_req = (state == S_RUN && op[3:2] == 2'b10) ||
                   (state == S_IMM && op == 4'hC);
  assign mem_op  = (op == 4'hA) || (op == 4'hB);
  assign wr_op   = (op == 4'h8) || (op == 4'hA) || (op == 4'hC);
  assign rd_op   = (op == 4'h9) || (op == 4'hB);
  assign bus_io  = bus_req && !mem_op;
  assign bus_wr  = bus_req && bus_gnt && wr_op;
  assign bus_rd  = bus_req && bus_gnt && rd_op;
  assign bus_addr  = mem_op ? rf[ra] : port_ext;
  assign bus_wdata = (op == 4'hC) ? imm : rf[rb];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_HALT;
      pc    <= '0;
      ir    <= '0;
      eq    <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      irq   <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        pc    <= '0;
        state <= S_RUN;
        err   <= 1'b0;
        irq   <= 1'b0;
      end else begin
        case (state)
          S_RUN: begin
            case (op)
              4'h0: pc <= pc + 1'b1;
              4'h1: pc <= eq ? cur[PCW-1:0] : pc + 1'b1;
              4'h2: pc <= cur[PCW-1:0];
              4'h3: begin
                state <= S_HALT;
                done  <= 1'b1;
                irq   <= irq_en;
              end
              4'h4, 4'h5, 4'h6, 4'hC: begin
                ir    <= rom_data;
                pc    <= pc + 1'b1;
                state <= S_IMM;
              end
              4'h8, 4'h9, 4'hA, 4'hB: begin
                if (bus_gnt) begin
                  pc <= pc + 1'b1;
                  if (rd_op) rf[rb] <= bus_rdata;
                end
              end
              default: begin
                state <= S_HALT;
                err   <= 1'b1;
              end
            endcase
          end
          S_IMM: begin
            if (op != 4'hC || bus_gnt) begin
              pc    <= pc + 1'b1;
              state <= S_RUN;
              case (op)
                4'h4:    rf[ra] <= imm;
                4'h5:    rf[ra] <= rf[ra] + imm;
                4'h6:    eq <= (rf[ra] == imm);
                default: ;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module dma_seq_core_chk #(
  parameter int PCW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           done,
  input logic           err,
  input logic           irq,
  input logic [PCW-1:0] rom_addr,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           bus_rd,
  input logic           bus_wr
);
  // R3
  strobe_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> (bus_req && bus_gnt));
  // R3
  stall_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !start) |=> $stable(rom_addr));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  halt_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !bus_req);
  // R9
  err_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !done);
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !start) |=> irq);
endmodule

bind dma_seq_core dma_seq_core_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err), .irq(irq),
  .rom_addr(rom_addr), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_rd(bus_rd), .bus_wr(bus_wr)
);

// File: tb/dma_seq_core_bench.sv
module dma_seq_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int PCW = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, irq_en = 1'b0, bus_gnt = 1'b1;
  logic done, err, irq, bus_req, bus_io, bus_rd, bus_wr;
  logic [PCW-1:0] rom_addr;
  logic [15:0] rom_data;
  logic [DW-1:0] bus_addr, bus_wdata, bus_rdata;

  logic [15:0] rom [0:31];
  logic [DW-1:0] mem [0:63];
  logic [DW-1:0] port_last [0:15];
  int port_cnt [0:15];
  int rd_cnt, done_cnt, bad_strobe;
  int compared = 0, mismatched = 0;
  bit rand_gnt = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_seq_core u_dma_seq_core (
    .clk(clk), .rst_n(rst_n), .start(start), .irq_en(irq_en),
    .done(done), .err(err), .irq(irq), .rom_addr(rom_addr), .rom_data(rom_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_io(bus_io), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  assign rom_data  = rom[rom_addr[4:0]];
  assign bus_rdata = bus_io ? ((bus_addr == 5) ? 32'h100 + rd_cnt : '0) : mem[bus_addr[5:0]];

  always @(posedge clk) begin
    if (done) done_cnt <= done_cnt + 1;
    if ((bus_rd || bus_wr) && !bus_gnt) bad_strobe <= bad_strobe + 1;
    if (bus_rd && bus_io && bus_addr == 5) rd_cnt <= rd_cnt + 1;
    if (bus_wr && !bus_io) mem[bus_addr[5:0]] <= bus_wdata;
    if (bus_wr && bus_io) begin
      port_last[bus_addr[3:0]] <= bus_wdata;
      port_cnt[bus_addr[3:0]]  <= port_cnt[bus_addr[3:0]] + 1;
    end
  end

  always @(negedge clk) if (rand_gnt) bus_gnt <= ($urandom % 4) != 0;

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [7:0] a, input logic [2:0] b);
    return {op, a, 1'b0, b};
  endfunction

  function automatic logic [15:0] jmp(input logic [3:0] op, input logic [11:0] t);
    return {op, t};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 32; i++) rom[i] = 16'h3000;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    done_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_halt();
    int n = 0;
    while (!done && !err && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 4000) chk(1'b0, "watchdog", n, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) begin port_last[i] = '0; port_cnt[i] = 0; end
    rd_cnt = 0; done_cnt = 0; bad_strobe = 0;
    clear_rom();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !err && !irq && !bus_req && !bus_rd && !bus_wr, "R1 reset outputs",
        {done, err, irq, bus_req, bus_rd, bus_wr}, 0);
    chk(rom_addr == 0, "R1 rom_addr", rom_addr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 (no start, still halted)
    chk(!bus_req && rom_addr == 0, "R1 idle", rom_addr, 0);

    // Program A: copy loop of 8 words from port 5 to memory 16.., random grant
    clear_rom();
    rom[0]  = enc(4'h4, 8'd1, 3'd0); rom[1]  = 16'd16;
    rom[2]  = enc(4'h4, 8'd2, 3'd0); rom[3]  = 16'd0;
    rom[4]  = enc(4'h9, 8'd5, 3'd3);
    rom[5]  = enc(4'hA, 8'd1, 3'd3);
    rom[6]  = enc(4'h5, 8'd1, 3'd0); rom[7]  = 16'd1;
    rom[8]  = enc(4'h5, 8'd2, 3'd0); rom[9]  = 16'd1;
    rom[10] = enc(4'h6, 8'd2, 3'd0); rom[11] = 16'd8;
    rom[12] = jmp(4'h1, 12'd14);
    rom[13] = jmp(4'h2, 12'd4);
    rom[14] = enc(4'hC, 8'd7, 3'd0); rom[15] = 16'h1234;
    rom[16] = enc(4'h4, 8'd4, 3'd0); rom[17] = 16'd16;
    rom[18] = enc(4'hB, 8'd4, 3'd5);
    rom[19] = enc(4'h8, 8'd6, 3'd5);
    rom[20] = 16'h3000;
    irq_en = 1'b1;
    rand_gnt = 1'b1;
    pulse_start();
    wait_halt();
    rand_gnt = 1'b0;
    bus_gnt = 1'b1;
    for (int k = 0; k < 8; k++)
      // R4 R6 copy result
      chk(mem[16+k] == 32'h100 + k, "R4 R6 copied word", mem[16+k], 32'h100 + k);
    chk(rd_cnt == 8, "R6 loop count", rd_cnt, 8);
    chk(port_last[7] == 32'h1234 && port_cnt[7] == 1, "R5 immediate port write", port_last[7], 32'h1234);
    chk(port_last[6] == 32'h100, "R4 memory read then port write", port_last[6], 32'h100);
    chk(bad_strobe == 0, "R3 strobe without grant", bad_strobe, 0);
    chk(done_cnt == 1, "R7 done pulse count", done_cnt, 1);
    chk(irq == 1'b1 && err == 1'b0, "R8 irq after end", {irq, err}, 2'b10);
    chk(!bus_req, "R10 no request after halt", bus_req, 0);

    // Program B: sign extension, long stall, undefined opcode
    clear_rom();
    rom[0] = enc(4'h4, 8'd0, 3'd0); rom[1] = 16'hFFFF;
    rom[2] = enc(4'h8, 8'd9, 3'd0);
    rom[3] = 16'h7000;
    irq_en = 1'b1;
    bus_gnt = 1'b0;
    pulse_start();
    // R2 start clears irq
    chk(irq == 1'b0, "R2 irq cleared by start", irq, 0);
    repeat (10) @(negedge clk);
    // R3 stalled with no grant
    chk(bus_req && port_cnt[9] == 0 && rom_addr == 2, "R3 stall", rom_addr, 2);
    bus_gnt = 1'b1;
    wait_halt();
    chk(port_last[9] == 32'hFFFF_FFFF, "R5 sign extension", port_last[9], 32'hFFFF_FFFF);
    chk(err == 1'b1, "R9 err set", err, 1);
    chk(done_cnt == 0 && irq == 1'b0, "R9 no done no irq", {done_cnt[0], irq}, 0);
    chk(!bus_req, "R10 no request after error", bus_req, 0);

    // Program C: flag branch skips a write, irq disabled
    clear_rom();
    rom[0] = 16'h0000;
    rom[1] = enc(4'h6, 8'd0, 3'd0); rom[2] = 16'hFFFF;
    rom[3] = jmp(4'h1, 12'd5);
    rom[4] = enc(4'h8, 8'd9, 3'd0);
    rom[5] = 16'h3000;
    irq_en = 1'b0;
    pulse_start();
    // R2 err cleared by start, registers kept
    chk(err == 1'b0, "R2 err cleared", err, 0);
    wait_halt();
    chk(port_cnt[9] == 1, "R6 taken branch skipped write", port_cnt[9], 1);
    chk(done_cnt == 1, "R7 single done", done_cnt, 1);
    chk(irq == 1'b0, "R8 irq off when disabled", irq, 0);

    // Program D: undefined opcode Fh
    clear_rom();
    rom[0] = 16'hF123;
    pulse_start();
    wait_halt();
    chk(err == 1'b1 && done_cnt == 0, "R9 opcode F", err, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule